// File: doc/BRIEF.md
# Configurable Sum-of-Products Array with Term Steering

This block is the combinational heart of one logic block in a programmable sum-of-products device. Thirty-six array inputs are each offered in true and inverted form. A configurable AND plane builds 86 product terms from these literals. A configurable OR plane then steers those terms into 16 sum outputs, one per downstream macrocell. A term is not owned by any one output. It can drive several sums at once, so a term that two outputs need is built once and shared rather than built twice. Each output accepts between zero and sixteen terms.

The whole configuration lives in a chain of flops that is written one bit at a time. The new contents build up in a shadow chain while the array keeps running on the old settings. A single load pulse then copies the shadow into the active settings in one clock edge, so the array never runs on a half-written configuration. The path from the array inputs to the sum outputs has no register in it. The clock only moves configuration data.

The configuration tool is expected to keep each output within sixteen terms. When a configuration steers more than that to one output, the block raises a per-output flag and caps that output at its sixteen lowest-numbered terms.

Top module: `pta_block`

## Requirements
- R1: Product term p is the AND of the literals selected for it. Its configuration field begins at bit p*89. Within that field, bit 2i selects input i in true form and bit 2i+1 selects input i inverted (i from 0 to 35).
- R2: The enable bit of term p is bit p*89+88. A term whose enable is 0 evaluates to 0. An enabled term with no literals selected evaluates to 1.
- R3: Bit p*89+72+o connects term p to sum o. A sum is the OR of its connected terms, and one term connected to several sums drives all of them.
- R4: A sum with no connected terms is 0.
- R5: A sum with exactly 16 connected terms uses all 16 and does not raise its flag in `overLimit`.
- R6: When more than 16 terms connect to sum o, `overLimit[o]` is 1 and sum o uses only the 16 connected terms with the lowest indices. Terms with the enable bit clear still count toward this limit.
- R7: While `cfgShift` is high, each clock edge shifts `cfgData` into the shadow chain. The first bit shifted lands in configuration bit 0 once all 7654 bits are in. Shifting alone never changes `sumOut` or `overLimit`.
- R8: A clock edge with `cfgLoad` high copies the whole shadow chain into the active configuration. The new setting is visible at the outputs right after that edge.
- R9: When `cfgShift` and `cfgLoad` are both high on the same edge, the active configuration receives the shadow contents as they stood before that edge's shift, and the shift still happens.
- R10: While `rstN` is low, both the shadow and the active configuration are cleared, so every sum and every flag reads 0.
- R11: The sum outputs follow `arrayIn` combinationally, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgShift | input | 1 | Shift one configuration bit in on this edge |
| cfgData | input | 1 | Serial configuration bit |
| cfgLoad | input | 1 | Copy the shadow chain into the active configuration |
| arrayIn | input | 36 | Array inputs from the interconnect |
| sumOut | output | 16 | Sum-of-products results, one per macrocell |
| overLimit | output | 16 | Per-sum flag: more than 16 terms are steered to it |

## Verification
The shift of the serial chain and the copy into the active configuration can fall on the same clock edge. To provoke this, the bench shifts a fresh configuration and raises the load strobe on the cycle that carries its final bit. It judges the result with its own model, evaluated on the chain contents predicted one position short: the earlier configuration's top bit sits at bit 0, followed by all but the last new bit. A separate load pulse on the following cycle must then bring in the complete new configuration.

// File: rtl/pta_pkg.sv
package pta_pkg;
  localparam int DefInputs   = 36;
  localparam int DefTerms    = 86;
  localparam int DefSums     = 16;
  localparam int DefMaxPerSum = 16;

  // Strobes passed from the configuration control to the datapath
  typedef struct packed {
    logic capture;
  } cfgStrobe_t;
endpackage

// File: rtl/pta_ctrl.sv
module pta_ctrl
  import pta_pkg::*;
#(
  parameter int CFG_BITS = 7654
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgShift,
  input  logic                cfgData,
  input  logic                cfgLoad,
  output cfgStrobe_t          strobe,
  output logic [CFG_BITS-1:0] shadow
);
  // Shadow chain: new bits enter at the top and move toward bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow <= '0;
    end else if (cfgShift) begin
      shadow <= {cfgData, shadow[CFG_BITS-1:1]};
    end
  end

  always_comb begin
    strobe.capture = cfgLoad;
  end
endmodule

// File: rtl/pta_limit.sv
module pta_limit #(
  parameter int NUM_TERMS = 86,
  parameter int MAX_TERMS = 16
) (
  input  logic [NUM_TERMS-1:0] conn,
  output logic [NUM_TERMS-1:0] keep,
  output logic                 over
);
  localparam int CntW = $clog2(NUM_TERMS + 1);

  logic [CntW-1:0] cnt;

  // Scan terms from index 0 upward and keep connections until the cap is reached
  always_comb begin
    cnt  = '0;
    keep = '0;
    for (int p = 0; p < NUM_TERMS; p++) begin
      if (conn[p]) begin
        if (cnt < CntW'(MAX_TERMS)) begin
          keep[p] = 1'b1;
        end
        cnt = cnt + 1'b1;
      end
    end
    over = (cnt > CntW'(MAX_TERMS));
  end
endmodule

// File: rtl/pta_datapath.sv
module pta_datapath
  import pta_pkg::*;
#(
  parameter int NUM_INPUTS = 36,
  parameter int NUM_TERMS  = 86,
  parameter int NUM_SUMS   = 16,
  parameter int MAX_TERMS  = 16,
  parameter int CFG_BITS   = 7654
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cfgStrobe_t                    strobe,
  input  logic [CFG_BITS-1:0]           shadow,
  input  logic [NUM_INPUTS-1:0]         arrayIn,
  output logic [NUM_SUMS-1:0]           sumOut,
  output logic [NUM_SUMS-1:0]           overLimit,
  output logic [NUM_SUMS*NUM_TERMS-1:0] connFlat,
  output logic [NUM_SUMS*NUM_TERMS-1:0] keepFlat
);
  localparam int LitW  = 2 * NUM_INPUTS;
  localparam int TermW = LitW + NUM_SUMS + 1;

  logic [CFG_BITS-1:0]  active;
  logic [LitW-1:0]      litVec;
  logic [NUM_TERMS-1:0] termVal;
  logic [NUM_TERMS-1:0] connMat [NUM_SUMS];
  logic [NUM_TERMS-1:0] keepMat [NUM_SUMS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= '0;
    end else if (strobe.capture) begin
      active <= shadow;
    end
  end

  for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_lit
    assign litVec[2*i]   = arrayIn[i];
    assign litVec[2*i+1] = ~arrayIn[i];
  end

  for (genvar p = 0; p < NUM_TERMS; p++) begin : g_term
    logic [LitW-1:0] sel;
    logic            en;
    assign sel        = active[p*TermW +: LitW];
    assign en         = active[p*TermW + TermW - 1];
    assign termVal[p] = en & (&(~sel | litVec));
    for (genvar o = 0; o < NUM_SUMS; o++) begin : g_conn
      assign connMat[o][p] = active[p*TermW + LitW + o];
    end
  end

  for (genvar o = 0; o < NUM_SUMS; o++) begin : g_sum
    pta_limit #(
      .NUM_TERMS(NUM_TERMS),
      .MAX_TERMS(MAX_TERMS)
    ) i_limit (
      .conn(connMat[o]),
      .keep(keepMat[o]),
      .over(overLimit[o])
    );
    assign sumOut[o] = |(termVal & keepMat[o]);
    assign connFlat[o*NUM_TERMS +: NUM_TERMS] = connMat[o];
    assign keepFlat[o*NUM_TERMS +: NUM_TERMS] = keepMat[o];
  end
endmodule

// File: rtl/pta_block.sv
module pta_block
  import pta_pkg::*;
#(
  parameter int NUM_INPUTS = DefInputs,
  parameter int NUM_TERMS  = DefTerms,
  parameter int NUM_SUMS   = DefSums,
  parameter int MAX_TERMS  = DefMaxPerSum
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgShift,
  input  logic                  cfgData,
  input  logic                  cfgLoad,
  input  logic [NUM_INPUTS-1:0] arrayIn,
  output logic [NUM_SUMS-1:0]   sumOut,
  output logic [NUM_SUMS-1:0]   overLimit
);
  localparam int TermW   = 2 * NUM_INPUTS + NUM_SUMS + 1;
  localparam int CfgBits = NUM_TERMS * TermW;

  cfgStrobe_t                    strobe;
  logic [CfgBits-1:0]            shadow;
  logic [NUM_SUMS*NUM_TERMS-1:0] connFlat;
  logic [NUM_SUMS*NUM_TERMS-1:0] keepFlat;

  pta_ctrl #(
    .CFG_BITS(CfgBits)
  ) i_ctrl (
    .clk(clk),
    .rstN(rstN),
    .cfgShift(cfgShift),
    .cfgData(cfgData),
    .cfgLoad(cfgLoad),
    .strobe(strobe),
    .shadow(shadow)
  );

  pta_datapath #(
    .NUM_INPUTS(NUM_INPUTS),
    .NUM_TERMS(NUM_TERMS),
    .NUM_SUMS(NUM_SUMS),
    .MAX_TERMS(MAX_TERMS),
    .CFG_BITS(CfgBits)
  ) i_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .shadow(shadow),
    .arrayIn(arrayIn),
    .sumOut(sumOut),
    .overLimit(overLimit),
    .connFlat(connFlat),
    .keepFlat(keepFlat)
  );
endmodule

// File: rtl/pta_checker.sv
module pta_checker #(
  parameter int NUM_INPUTS = 36,
  parameter int NUM_TERMS  = 86,
  parameter int NUM_SUMS   = 16,
  parameter int MAX_TERMS  = 16
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          cfgLoad,
  input logic [NUM_INPUTS-1:0]         arrayIn,
  input logic [NUM_SUMS-1:0]           sumOut,
  input logic [NUM_SUMS-1:0]           overLimit,
  input logic [NUM_SUMS*NUM_TERMS-1:0] connFlat,
  input logic [NUM_SUMS*NUM_TERMS-1:0] keepFlat
);
  // R7: without a load, the flags cannot move
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> $stable(overLimit));

  // R7, R8: without a load and with steady inputs, the sums cannot move
  a_r8_sums_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> (!$stable(arrayIn) || $stable(sumOut)));

  for (genvar o = 0; o < NUM_SUMS; o++) begin : g_chk
    // R6: never more than the cap of terms reaches one sum
    a_r6_cap: assert property (@(posedge clk) disable iff (!rstN)
      $countones(keepFlat[o*NUM_TERMS +: NUM_TERMS]) <= MAX_TERMS);

    // R6: a flagged sum keeps exactly the cap
    a_r6_flag_full: assert property (@(posedge clk) disable iff (!rstN)
      overLimit[o] |-> ($countones(keepFlat[o*NUM_TERMS +: NUM_TERMS]) == MAX_TERMS));

    // R5: an unflagged sum keeps every connection
    a_r5_keep_all: assert property (@(posedge clk) disable iff (!rstN)
      !overLimit[o] |-> (keepFlat[o*NUM_TERMS +: NUM_TERMS] == connFlat[o*NUM_TERMS +: NUM_TERMS]));
  end
endmodule

bind pta_block pta_checker #(
  .NUM_INPUTS(NUM_INPUTS),
  .NUM_TERMS(NUM_TERMS),
  .NUM_SUMS(NUM_SUMS),
  .MAX_TERMS(MAX_TERMS)
) i_pta_checker (
  .clk(clk),
  .rstN(rstN),
  .cfgLoad(cfgLoad),
  .arrayIn(arrayIn),
  .sumOut(sumOut),
  .overLimit(overLimit),
  .connFlat(connFlat),
  .keepFlat(keepFlat)
);

// File: tb/test_pta_block.sv
module test_pta_block;
  localparam int NI  = 36;
  localparam int NT  = 86;
  localparam int NS  = 16;
  localparam int MX  = 16;
  localparam int LW  = 2 * NI;
  localparam int TW  = LW + NS + 1;
  localparam int TOT = NT * TW;

  // Directed table: {arrayIn, expected sumOut} for the directed configuration
  localparam logic [NI+NS-1:0] VEC [6] = '{
    {36'h0,         16'h0004},
    {36'h1,         16'h0007},
    {36'h3,         16'h0004},
    {36'hC,         16'h0005},
    {36'hD,         16'h0007},
    {36'hFFFFFFFFF, 16'h0005}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgShift = 1'b0;
  logic          cfgData = 1'b0;
  logic          cfgLoad = 1'b0;
  logic [NI-1:0] arrayIn = '0;
  logic [NS-1:0] sumOut;
  logic [NS-1:0] overLimit;

  int errors = 0;
  int checks = 0;

  logic [TOT-1:0] cfgA;
  logic [TOT-1:0] cfgB;
  logic [TOT-1:0] cfgMix;
  logic [TOT-1:0] cfgPrev;

  always #2.5 clk = ~clk;

  pta_block i_pta_block (
    .clk(clk),
    .rstN(rstN),
    .cfgShift(cfgShift),
    .cfgData(cfgData),
    .cfgLoad(cfgLoad),
    .arrayIn(arrayIn),
    .sumOut(sumOut),
    .overLimit(overLimit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model: {overLimit, sumOut} from the requirement encoding
  function automatic logic [31:0] refEval(input logic [TOT-1:0] c, input logic [NI-1:0] x);
    logic [NT-1:0] tv;
    logic [NS-1:0] s;
    logic [NS-1:0] ov;
    for (int p = 0; p < NT; p++) begin
      logic v;
      v = c[p*TW + TW - 1];
      for (int i = 0; i < NI; i++) begin
        if (c[p*TW + 2*i] && !x[i]) v = 1'b0;
        if (c[p*TW + 2*i + 1] && x[i]) v = 1'b0;
      end
      tv[p] = v;
    end
    for (int o = 0; o < NS; o++) begin
      int n;
      n = 0;
      s[o] = 1'b0;
      for (int p = 0; p < NT; p++) begin
        if (c[p*TW + LW + o]) begin
          if (n < MX) s[o] = s[o] | tv[p];
          n++;
        end
      end
      ov[o] = (n > MX);
    end
    return {ov, s};
  endfunction

  task automatic shiftIn(input logic [TOT-1:0] v, input bit loadOnLast);
    for (int k = 0; k < TOT; k++) begin
      @(negedge clk);
      cfgShift = 1'b1;
      cfgData  = v[k];
      if (loadOnLast && k == TOT - 1) cfgLoad = 1'b1;
    end
    @(negedge clk);
    cfgShift = 1'b0;
    cfgLoad  = 1'b0;
  endtask

  task automatic loadPulse();
    @(negedge clk);
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic checkVec(input string req, input logic [TOT-1:0] c, input logic [NI-1:0] x);
    logic [31:0] e;
    arrayIn = x;
    #1;
    e = refEval(c, x);
    chk(req, {overLimit, sumOut}, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10: reset state
    arrayIn = '1;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset sums", 32'(sumOut), 32'h0);
    chk("R10 reset flags", 32'(overLimit), 32'h0);
    rstN = 1'b1;

    // Directed configuration: R1, R2, R3, R4
    cfgA = '0;
    cfgA[0*TW + 0] = 1'b1;           // term0: in0 true
    cfgA[0*TW + 3] = 1'b1;           // term0: in1 inverted
    cfgA[0*TW + LW + 0] = 1'b1;      // shared to sum0
    cfgA[0*TW + LW + 1] = 1'b1;      // and to sum1
    cfgA[0*TW + TW - 1] = 1'b1;
    cfgA[1*TW + LW + 2] = 1'b1;      // term1: no literals, enabled
    cfgA[1*TW + TW - 1] = 1'b1;
    cfgA[2*TW + LW + 3] = 1'b1;      // term2: no literals, disabled
    cfgA[3*TW + 4] = 1'b1;           // term3: in2 true
    cfgA[3*TW + 6] = 1'b1;           // term3: in3 true
    cfgA[3*TW + LW + 0] = 1'b1;
    cfgA[3*TW + TW - 1] = 1'b1;

    shiftIn(cfgA, 1'b0);
    // R7: shifting alone leaves outputs at the reset configuration
    arrayIn = 36'h1;
    #1;
    chk("R7 shift only", 32'(sumOut), 32'h0);
    loadPulse();
    #1;
    // R8: load visible right after the edge
    chk("R8 after load", 32'(sumOut), 32'h0007);

    for (int v = 0; v < 6; v++) begin
      logic [NS-1:0] e;
      arrayIn = VEC[v][NI+NS-1:NS];
      #1;
      e = VEC[v][NS-1:0];
      chk("R1 R2 R3 R4 table", 32'(sumOut), 32'(e));
      chk("R4 no flags", 32'(overLimit), 32'h0);
    end

    // R11: combinational response between edges
    @(posedge clk);
    #1;
    arrayIn = 36'h0;
    #0.5;
    chk("R11 comb low", 32'(sumOut[0]), 32'h0);
    arrayIn = 36'h1;
    #0.5;
    chk("R11 comb high", 32'(sumOut[0]), 32'h1);

    // Limit configuration: R5 (sum4 with 16 terms), R6 (sum5 with 18 terms)
    cfgB = '0;
    for (int p = 10; p < 26; p++) begin
      cfgB[p*TW + 2*(p-10)] = 1'b1;
      cfgB[p*TW + LW + 4] = 1'b1;
      cfgB[p*TW + TW - 1] = 1'b1;
    end
    for (int p = 30; p < 48; p++) begin
      cfgB[p*TW + 2*(p-30)] = 1'b1;
      cfgB[p*TW + LW + 5] = 1'b1;
      cfgB[p*TW + TW - 1] = 1'b1;
    end
    shiftIn(cfgB, 1'b0);
    // R7: still the directed configuration
    checkVec("R7 old config kept", cfgA, 36'hD);
    loadPulse();
    arrayIn = 36'h1 << 15;
    #1;
    chk("R5 sixteenth term used", 32'(sumOut), 32'h0030);
    chk("R6 flag only on sum5", 32'(overLimit), 32'h0020);
    arrayIn = 36'h1 << 16;
    #1;
    chk("R6 term 17 dropped", 32'(sumOut), 32'h0000);
    arrayIn = 36'h1 << 17;
    #1;
    chk("R6 term 18 dropped", 32'(sumOut), 32'h0000);
    arrayIn = 36'h1;
    #1;
    chk("R5 R6 lowest term", 32'(sumOut), 32'h0030);

    // R9: load on the same edge as the final shift
    cfgMix = {cfgA[TOT-2:0], cfgB[TOT-1]};
    shiftIn(cfgA, 1'b1);
    checkVec("R9 concurrent load", cfgMix, 36'h1);
    checkVec("R9 concurrent load", cfgMix, 36'hD);
    checkVec("R9 concurrent load", cfgMix, 36'h3 << 1);
    loadPulse();
    checkVec("R9 full after plain load", cfgA, 36'h1);
    checkVec("R9 full after plain load", cfgA, 36'hC);

    // Random configurations against the model: R1, R3, R6
    cfgPrev = cfgA;
    for (int r = 0; r < 6; r++) begin
      logic [TOT-1:0] c;
      c = '0;
      for (int p = 0; p < NT; p++) begin
        c[p*TW + ($urandom % LW)] = 1'b1;
        if ($urandom % 2 == 0) c[p*TW + ($urandom % LW)] = 1'b1;
        for (int o = 0; o < NS; o++) begin
          if ($urandom % 6 == 0) c[p*TW + LW + o] = 1'b1;
        end
        c[p*TW + TW - 1] = (($urandom % 8) != 0);
      end
      shiftIn(c, 1'b0);
      checkVec("R7 random hold", cfgPrev, 36'({$urandom(), $urandom()}));
      loadPulse();
      for (int v = 0; v < 6; v++) begin
        checkVec("R1 R3 R6 random", c, 36'({$urandom(), $urandom()}));
      end
      cfgPrev = c;
    end

    // R10: reset in mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    arrayIn = '1;
    #1;
    chk("R10 mid reset sums", 32'(sumOut), 32'h0);
    chk("R10 mid reset flags", 32'(overLimit), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    loadPulse();
    #1;
    chk("R10 shadow cleared", {16'(overLimit), 16'(sumOut)}, 32'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule